// File: doc/BRIEF.md
# Polled Command Handshake Controller

This block is the device side of a polled command dialogue. A host reaches it over a small register bus with one-cycle reads and writes. The host polls a status register until the device is free, loads a byte into the output-data register, and then writes the control register. That write carries the command-ready flag and the direction flag.

The controller sees the pending command and raises busy before it does anything else. It then decodes the direction. A write command hands the byte to an output port through a request/acknowledge pair. A read command finishes at once and moves no data.

When the command completes, the controller clears busy and the whole control register, and the host may issue its next command. Host writes that arrive while a command is in flight are refused, and they leave a sticky error bit behind.

Top module: `cmd_handshake_ctrl`

## Requirements
- R1: After reset, every register reads zero and `out_req` is low.
- R2: The register map has three registers, each 8 bits wide:
  - Offset 0 is status: bit 0 is busy and bit 1 is error.
  - Offset 1 is control: bit 0 is command-ready and bit 1 is write.
  - Offset 2 is output data.
  - Offset 3 and all unnamed bits read 0.
  - `bus_rdata` shows the register at `bus_addr` in the same cycle.
  - A write lands at the next rising edge.
- R3: Suppose the edge that stores a control write also sets command-ready. The next edge then sets busy. Busy never rises unless command-ready is set.
- R4: For a write command, `out_req` rises one edge after busy rises. At that point `out_data` equals the output-data register.
- R5: `out_req` and `out_data` hold steady until `out_ack` is high at a rising edge. At that edge, `out_req`, busy and the whole control register all clear together.
- R6: For a read command (write bit 0), busy stays high for exactly one cycle, the control register clears with it, and `out_req` never rises.
- R7: While busy or command-ready is set, a host write to control or to output data is ignored, and it sets the error bit.
- R8: The error bit stays set until the host writes status with bit 1 at 1. A status write with bit 1 at 0 leaves the error bit as it was.
- R9: `out_ack` has no effect while no request is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| out_req | output | 1 | Output byte request |
| out_data | output | 8 | Output byte |
| out_ack | input | 1 | Output byte acknowledge |

## Verification
Each result is due on a fixed cycle, counted in rising edges:

| Result | When it is due |
|---|---|
| Register write | Visible after 1 edge |
| Busy | Rises 1 edge after command-ready is stored |
| `out_req` | Rises 1 edge after busy rises |
| Completion of a write command | The edge that samples `out_ack` high |
| Completion of a read command | 1 edge after busy rises |

A behavioural model in the bench advances on each rising edge from the same inputs. The outputs and the read data are compared with it shortly after each edge. Directed checks drive on the falling edge and sample before the next rising edge, so every expected value is tied to an exact edge count.

// File: rtl/cmd_handshake_ctrl.sv
module cmd_handshake_ctrl #(
  parameter int DW = 8,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          out_req,
  output logic [DW-1:0] out_data,
  input  logic          out_ack
);

  localparam logic [AW-1:0] A_STAT = AW'(0);
  localparam logic [AW-1:0] A_CTRL = AW'(1);
  localparam logic [AW-1:0] A_DATA = AW'(2);
  localparam int PAD = DW - 2;

  typedef enum logic [1:0] {S_IDLE, S_DECODE, S_XFER} state_t;
  state_t state;

  logic busy_q, err_q, rdy_q, wr_q;
  logic [DW-1:0] dout_q;

  wire locked  = busy_q | rdy_q;
  wire wr_stat = bus_wr && bus_addr == A_STAT;
  wire wr_ctrl = bus_wr && bus_addr == A_CTRL;
  wire wr_data = bus_wr && bus_addr == A_DATA;
  wire finish  = (state == S_DECODE && !wr_q) || (state == S_XFER && out_ack);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      busy_q <= 1'b0;
      err_q  <= 1'b0;
      rdy_q  <= 1'b0;
      wr_q   <= 1'b0;
      dout_q <= '0;
    end else begin
      if (wr_stat && bus_wdata[1]) err_q <= 1'b0;
      if ((wr_ctrl || wr_data) && locked) err_q <= 1'b1;
      if (wr_ctrl && !locked) {wr_q, rdy_q} <= bus_wdata[1:0];
      if (wr_data && !locked) dout_q <= bus_wdata;
      case (state)
        S_IDLE:   if (rdy_q) begin busy_q <= 1'b1; state <= S_DECODE; end
        S_DECODE: if (wr_q) state <= S_XFER;
        default:  ;
      endcase
      if (finish) begin
        busy_q <= 1'b0;
        rdy_q  <= 1'b0;
        wr_q   <= 1'b0;
        state  <= S_IDLE;
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_STAT:  bus_rdata = {{PAD{1'b0}}, err_q, busy_q};
      A_CTRL:  bus_rdata = {{PAD{1'b0}}, wr_q, rdy_q};
      A_DATA:  bus_rdata = dout_q;
      default: bus_rdata = '0;
    endcase
  end

  assign out_req  = (state == S_XFER);
  assign out_data = dout_q;

  a_r3_busy_needs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> rdy_q);
  a_r4_req_under_busy: assert property (@(posedge clk) disable iff (!rst_n)
    out_req |-> busy_q);
  a_r5_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (out_req && !out_ack) |=> (out_req && $stable(out_data)));
  a_r5_free_together: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> (!rdy_q && !wr_q && !out_req));
  a_r6_read_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DECODE && !wr_q) |=> (!out_req && !busy_q));
  a_r7_locked_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && locked) |=> ($stable(dout_q) && err_q));

endmodule

// File: tb/sim_cmd_handshake_ctrl.sv
`timescale 1ns/1ps
module sim_cmd_handshake_ctrl;
  logic clk = 0, rst_n = 0, bus_wr = 0, out_ack = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata, out_data;
  logic out_req;
  int n_tests = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  cmd_handshake_ctrl u0 (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .out_req(out_req), .out_data(out_data),
    .out_ack(out_ack));

  // behavioural reference
  bit m_busy, m_err, m_rdy, m_wr, m_req;
  bit [7:0] m_dout;
  always @(posedge clk) begin
    bit lk, rdy0, req0;
    if (!rst_n) begin
      {m_busy, m_err, m_rdy, m_wr, m_req} = '0; m_dout = 0;
    end else begin
      lk = m_busy || m_rdy; rdy0 = m_rdy; req0 = m_req;
      if (bus_wr) begin
        if (bus_addr == 0 && bus_wdata[1]) m_err = 0;
        if ((bus_addr == 1 || bus_addr == 2) && lk) m_err = 1;
        else if (bus_addr == 1) {m_wr, m_rdy} = bus_wdata[1:0];
        else if (bus_addr == 2) m_dout = bus_wdata;
      end
      if (req0) begin
        if (out_ack) {m_req, m_busy, m_rdy, m_wr} = '0;
      end else if (m_busy) begin
        if (m_wr) m_req = 1; else {m_busy, m_rdy, m_wr} = '0;
      end else if (rdy0) m_busy = 1;
    end
  end

  function automatic bit [7:0] m_read(input bit [1:0] a);
    case (a)
      0: return {6'b0, m_err, m_busy};
      1: return {6'b0, m_wr, m_rdy};
      2: return m_dout;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      check("R4/R5 out_req", out_req, m_req);
      if (m_req) check("R4 out_data", out_data, m_dout);
      check("R2 bus_rdata", bus_rdata, m_read(bus_addr));
    end
  end

  task automatic wr(input bit [1:0] a, input bit [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic peek(input bit [1:0] a, output bit [7:0] d);
    bus_addr = a; #0.5; d = bus_rdata;
  endtask

  task automatic wait_free();
    bit [7:0] s;
    forever begin
      @(negedge clk); peek(0, s);
      if (!s[0] && !m_rdy) break;
    end
  endtask

  initial begin
    #20000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    bit [7:0] d;
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 4; a++) begin peek(a[1:0], d); check("R1 reg after reset", d, 0); end
    check("R1 out_req after reset", out_req, 0);
    rst_n = 1;
    // R2 map
    wr(2, 8'hA5); peek(2, d); check("R2 data readback", d, 8'hA5);
    peek(3, d); check("R2 offset 3 reads 0", d, 0);
    // R9 ack while idle
    @(negedge clk); out_ack = 1; @(negedge clk); out_ack = 0;
    check("R9 no req after stray ack", out_req, 0);
    peek(0, d); check("R9 status after stray ack", d, 0);
    // R3/R4/R5 write command
    wr(1, 8'h03);
    peek(1, d); check("R2 control readback", d, 8'h03);
    peek(0, d); check("R3 busy not yet", d[0], 0);
    @(negedge clk); peek(0, d); check("R3 busy set", d[0], 1);
    check("R4 req not yet", out_req, 0);
    @(negedge clk); check("R4 req risen", out_req, 1); check("R4 byte", out_data, 8'hA5);
    // R7 writes while busy
    wr(2, 8'h11); peek(2, d); check("R7 data kept", d, 8'hA5);
    peek(0, d); check("R7 error set", d[1], 1);
    wr(1, 8'h00); peek(1, d); check("R7 control kept", d, 8'h03);
    repeat (3) @(negedge clk);
    check("R5 req held", out_req, 1); check("R5 byte held", out_data, 8'hA5);
    out_ack = 1; @(negedge clk); out_ack = 0;
    check("R5 req cleared", out_req, 0);
    peek(0, d); check("R5 busy cleared", d[0], 0);
    peek(1, d); check("R5 control cleared", d, 0);
    // R8 sticky error
    wr(0, 8'h01); peek(0, d); check("R8 error kept", d[1], 1);
    wr(0, 8'h02); peek(0, d); check("R8 error cleared", d[1], 0);
    // R6 read command
    wait_free();
    wr(1, 8'h01);
    @(negedge clk); peek(0, d); check("R6 busy one cycle", d[0], 1);
    @(negedge clk); peek(0, d); check("R6 busy cleared", d[0], 0);
    peek(1, d); check("R6 control cleared", d, 0);
    check("R6 no req", out_req, 0);
    // R7 write during pending (ready set, busy not yet)
    wr(1, 8'h01); wr(2, 8'h77); peek(2, d); check("R7 pending data kept", d, 8'hA5);
    wr(0, 8'h02);
    // varied bytes and ack delays
    for (int k = 0; k < 6; k++) begin
      wait_free();
      wr(2, 8'(8'h3C + 37 * k));
      wr(1, 8'h03);
      while (!out_req) @(negedge clk);
      repeat (k) @(negedge clk);
      check("R4 byte loop", out_data, 8'(8'h3C + 37 * k));
      out_ack = 1; @(negedge clk); out_ack = 0;
      check("R5 req dropped loop", out_req, 0);
    end
    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule